// File: doc/BRIEF.md
# Configuration read-back stream checker

A current-input converter answers its configuration load by sending back a fixed-length serial record. This block listens to that stream and decides whether it is correct. A start pulse arms a capture and records the configuration word that was sent to the converter. The block then takes one data bit for every sample-enable strobe. The strobe is expected to mark rising edges of the converter's data clock, and every field arrives MSB first.

Each record holds four fields in order: the echoed configuration word, a revision identifier, a run of zeros and a fixed 70-bit test pattern. The whole record has to arrive twice in a row. The block compares every bit with the bit it expects at that position. A single wrong bit raises the fail flag at once. When the last bit of the second record has been taken, a one-cycle done pulse is raised. The pass flag is then set only if no bit was wrong. Both flags keep their values until the next start pulse.

With the default parameters one record is 320 bits (12 + 4 + 234 + 70) and the whole read-back is 640 bits.

Top module: `rdbk_checker`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, done, pass and fail are all 0.
- R2: A start pulse clears done, pass and fail in the following cycle and arms a capture at record bit position 0. It also latches cfg_word as the expected echo.
- R3: Record positions 0..11 must equal the latched configuration word, MSB first. Position 0 carries cfg_word bit 11 and position 11 carries bit 0.
- R4: Record positions 12..15 must carry the revision identifier 4'b0001, MSB first, so only position 15 is 1.
- R5: Record positions 16..249 must all be 0 (the zero run, GAP_W = 234 by default).
- R6: Record positions 250..319 must carry the low 70 bits of 72'h30F066012480F69055, MSB first. Position 250 carries pattern bit 69.
- R7: The record must repeat: stream bits 320..639 are checked against the same layout as bits 0..319.
- R8: In the cycle after the 640th accepted bit, done is 1 for exactly one cycle. pass equals 1 in that cycle if and only if no accepted bit mismatched, and pass and fail are never both 1.
- R9: In the cycle after a mismatching bit is accepted, fail is 1. It stays 1 and pass stays 0 until the next start pulse.
- R10: A sample_en strobe while no capture is armed (after reset, or after done) is ignored: done stays 0 and pass and fail keep their values.
- R11: When start and sample_en are high in the same cycle, start wins. That bit is discarded, and the next accepted bit is taken as position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms a new capture and latches cfg_word |
| cfg_word | input | 12 | Configuration word sent to the converter |
| sample_en | input | 1 | One strobe per data-clock rising edge; take sdata |
| sdata | input | 1 | Serial read-back data bit |
| done | output | 1 | One-cycle pulse after the final bit |
| pass | output | 1 | Both records matched; held until next start |
| fail | output | 1 | A mismatch was seen; held until next start |

## Verification
A start pulse can land in the same cycle as a sample strobe, so restart and bit capture compete for the position counter. The bench provokes this by raising start together with sample_en, with sdata set to the correct bit for position 0. It then sends a full clean 640-bit stream. If the coincident bit had been accepted, every later bit would be judged one position off and the run would fail. It would also finish one bit early. The check therefore requires done and pass to appear exactly after the 640th strobe that follows the start.

// File: rtl/rdbk_checker.sv
module rdbk_checker #(
  parameter int CFG_W = 12,
  parameter int REV_W = 4,
  parameter logic [REV_W-1:0] REV_VAL = 4'b0001,
  parameter int GAP_W = 234,
  parameter int PAT_W = 70,
  parameter logic [PAT_W-1:0] PAT_VAL = 70'h30F066012480F69055,
  parameter int REPEATS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             sample_en,
  input  logic             sdata,
  output logic             done,
  output logic             pass,
  output logic             fail
);
  localparam int REC_W   = CFG_W + REV_W + GAP_W + PAT_W;
  localparam int PW      = $clog2(REC_W);
  localparam int RW      = (REPEATS > 1) ? $clog2(REPEATS) : 1;
  localparam int CIW     = (CFG_W > 1) ? $clog2(CFG_W) : 1;
  localparam int RIW     = (REV_W > 1) ? $clog2(REV_W) : 1;
  localparam int PIW     = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam int REV_END = CFG_W + REV_W;
  localparam int GAP_END = REV_END + GAP_W;

  logic             active;
  logic [PW-1:0]    pos;
  logic [RW-1:0]    rec;
  logic [CFG_W-1:0] cfg_q;
  logic             exp_bit;
  logic             take;
  logic             bad;
  logic             last_pos;
  logic             last_rec;

  always_comb begin
    int p;
    p = int'(pos);
    if (p < CFG_W)
      exp_bit = cfg_q[CIW'(CFG_W - 1 - p)];
    else if (p < REV_END)
      exp_bit = REV_VAL[RIW'(REV_END - 1 - p)];
    else if (p < GAP_END)
      exp_bit = 1'b0;
    else
      exp_bit = PAT_VAL[PIW'(REC_W - 1 - p)];
  end

  assign take     = active && sample_en && !start;
  assign bad      = sdata != exp_bit;
  assign last_pos = pos == PW'(REC_W - 1);
  assign last_rec = rec == RW'(REPEATS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      rec    <= '0;
      cfg_q  <= '0;
      done   <= 1'b0;
      pass   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        pos    <= '0;
        rec    <= '0;
        cfg_q  <= cfg_word;
        pass   <= 1'b0;
        fail   <= 1'b0;
      end else if (take) begin
        if (bad) fail <= 1'b1;
        if (last_pos) begin
          pos <= '0;
          if (last_rec) begin
            active <= 1'b0;
            done   <= 1'b1;
            pass   <= !(fail || bad);
          end else begin
            rec <= rec + 1'b1;
          end
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rdbk_checker_chk.sv
module rdbk_checker_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic done,
  input logic pass,
  input logic fail
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));
  // R8
  pass_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> done);
  // R8
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass && !start |=> pass);
  // R9
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !start |=> fail);
  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && !pass && !fail);
endmodule

bind rdbk_checker rdbk_checker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .done(done), .pass(pass), .fail(fail)
);

// File: tb/sim_rdbk_checker.sv
`timescale 1ns/1ps
module sim_rdbk_checker;
  localparam logic [71:0] PAT72 = 72'h30F066012480F69055;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [11:0] cfg_word = '0;
  logic sample_en = 1'b0;
  logic sdata = 1'b0;
  logic done, pass, fail;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  rdbk_checker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
    .sample_en(sample_en), .sdata(sdata), .done(done), .pass(pass), .fail(fail)
  );

  function automatic logic exp_bit(logic [11:0] cfg, int n);
    int p;
    p = n % 320;
    if (p < 12) return cfg[11 - p];
    if (p < 16) return p == 15;
    if (p < 250) return 1'b0;
    return PAT72[69 - (p - 250)];
  endfunction

  task automatic check(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic do_start(logic [11:0] cfg, logic with_bit);
    @(negedge clk);
    start = 1'b1; cfg_word = cfg;
    sample_en = with_bit; sdata = exp_bit(cfg, 0);
    @(posedge clk); #1;
    check("R2 done cleared", done, 1'b0);
    check("R2 pass cleared", pass, 1'b0);
    check("R2 fail cleared", fail, 1'b0);
    @(negedge clk);
    start = 1'b0; sample_en = 1'b0;
  endtask

  // Sends the stream for cfg_echo with optional flipped bit; sent word was cfg_sent.
  task automatic run_stream(logic [11:0] cfg_sent, logic [11:0] cfg_echo, int bad_pos, int count);
    logic first_bad_seen = 1'b0;
    for (int i = 0; i < count; i++) begin
      if (i % 7 == 3) begin
        @(negedge clk); sample_en = 1'b0;
      end
      @(negedge clk);
      sample_en = 1'b1;
      sdata = exp_bit(cfg_echo, i) ^ (i == bad_pos);
      @(posedge clk); #1;
      if (!first_bad_seen && (i == bad_pos || exp_bit(cfg_echo, i) != exp_bit(cfg_sent, i))) begin
        first_bad_seen = 1'b1;
        check("R9 fail rises after bad bit", fail, 1'b1);
      end else if (!first_bad_seen && (i == bad_pos - 1)) begin
        check("R9 fail low before bad bit", fail, 1'b0);
      end
      if (i < count - 1 && (i == 319 || i == 638)) check("R8 no early done", done, 1'b0);
    end
    @(negedge clk); sample_en = 1'b0;
    if (count == 640) begin
      check("R8 done after 640th bit", done, 1'b1);
      check("R8 pass verdict", pass, !first_bad_seen);
      check("R9 fail verdict", fail, first_bad_seen);
      @(posedge clk); #1;
      check("R8 done one cycle", done, 1'b0);
      check("R8 pass held", pass, !first_bad_seen);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL R8 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] cfgs [6] = '{12'hF80, 12'h000, 12'hFFF, 12'hA5A, 12'h5A5, 12'hF81};
    int bads [12] = '{0, 11, 12, 14, 15, 16, 249, 250, 319, 320, 331, 639};
    repeat (3) @(posedge clk);
    #1;
    check("R1 done in reset", done, 1'b0);
    check("R1 pass in reset", pass, 1'b0);
    check("R1 fail in reset", fail, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 done after reset", done, 1'b0);
    check("R1 pass after reset", pass, 1'b0);

    // R10: strobes before any start are ignored
    @(negedge clk); sample_en = 1'b1; sdata = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R10 idle done", done, 1'b0);
    check("R10 idle fail", fail, 1'b0);
    @(negedge clk); sample_en = 1'b0;

    // R3 R4 R5 R6 R7: clean streams over several configuration words
    foreach (cfgs[k]) begin
      do_start(cfgs[k], 1'b0);
      run_stream(cfgs[k], cfgs[k], -1, 640);
    end

    // R10: strobes after done leave pass untouched
    @(negedge clk); sample_en = 1'b1; sdata = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check("R10 post-done done", done, 1'b0);
    check("R10 post-done pass", pass, 1'b1);
    check("R10 post-done fail", fail, 1'b0);
    @(negedge clk); sample_en = 1'b0;

    // R3 R4 R5 R6 R7 R9: single flipped bit at field boundaries
    foreach (bads[k]) begin
      do_start(12'hF80, 1'b0);
      run_stream(12'hF80, 12'hF80, bads[k], 640);
    end

    // R3: echo differs from the latched word in one bit
    do_start(12'hF80, 1'b0);
    run_stream(12'hF80, 12'hF90, -1, 640);

    // R2: restart mid-capture clears a latched fail
    do_start(12'h123, 1'b0);
    run_stream(12'h123, 12'h123, 5, 100);
    check("R9 fail mid-capture", fail, 1'b1);
    do_start(12'h123, 1'b0);
    run_stream(12'h123, 12'h123, -1, 640);

    // R11: start coincident with a strobe discards that bit
    do_start(12'hF80, 1'b1);
    run_stream(12'hF80, 12'hF80, -1, 640);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule